// File: doc/BRIEF.md
# Receive Frame Filter and Ring Writer

This block sits between the receive side of an Ethernet MAC and a byte-wide shared packet buffer. Frames arrive one byte per cycle on a valid/ready stream with an end-of-frame marker. The block decides whether to keep each frame. The decision uses the enable, promiscuous, station-address, group-hash, short-frame and long-frame rules. A kept frame is stored in a circular receive region of the buffer, which spans addresses 3072 to 16383. The frame goes in at the current write pointer, behind a four-byte status-and-length header and zero-padded to the minimum frame size.

Frame bytes are written as they arrive, at their final place after the header slot. The header is written last. Only after that does the write pointer move and the receive interrupt status get set. A rejected frame therefore leaves the write pointer where it was. The unread data ahead of the host's read pointer is never overwritten, because each data write is gated against the free space measured when the frame started. A new frame is accepted only while that free space is above one maximum-size frame.

Top module: `rxf_ring_writer`

## Requirements
- R1: While `cfg_enable` is low at a frame's first byte, the frame is consumed, no buffer byte is written, and `wr_ptr` and `rx_irq` do not change.
- R2: Free space is `rd_ptr - wr_ptr` modulo 13312, and equal pointers count as 13312 free bytes. Between frames, with `cfg_enable` high, `in_ready` is low while free space is 1522 or less, and high once it exceeds 1522.
- R3: With `cfg_promisc` low, a frame whose first byte has bit 0 clear is kept only if its first six bytes equal the station address. Byte k is compared with `station_addr[8k+7:8k]`.
- R4: With `cfg_promisc` low, a frame whose first byte has bit 0 set is kept only if `cfg_all_group` is high or `group_table[h]` is set. h is bits 31:26 of a CRC-32 over the six destination bytes, taken least-significant bit first, with polynomial 0x04C11DB7 and initial value all ones. Bit h is bit h[2:0] of table byte h[5:3]. When such a frame is kept, `stat_group` is set.
- R5: With `cfg_promisc` high, the address rules are skipped; the length rules still apply.
- R6: A frame of 6 to 63 bytes that passes the address rules, with `cfg_keep_short` low, is dropped and sets `stat_short`. With `cfg_keep_short` high it is kept. A frame under 6 bytes is always dropped.
- R7: A frame over 1522 bytes is dropped when `cfg_drop_long` is high and may be kept when it is low.
- R8: A kept frame of length L is stored as follows. At `wr_ptr` go the bytes 0x01 and 0x00, then the low and high byte of S = max(L, 64). The L frame bytes follow, then zero bytes up to S. All addresses wrap from 16384 to 3072.
- R9: `wr_ptr` resets to 3072 and is always even. After a kept frame it advances by 4 + S, rounded up to even, and wraps from 16384 to 3072.
- R10: If 4 + S, rounded up to even, is not below the free space at the frame's first byte, the frame is dropped. No write lands at or beyond `rd_ptr`.
- R11: `rx_irq` is set when a frame has been stored. `stat_clr` clears `rx_irq`, `stat_group` and `stat_short`.
- R12: A dropped frame leaves `wr_ptr` unchanged and does not set `rx_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Receive enable |
| cfg_promisc | input | 1 | Accept every destination |
| cfg_all_group | input | 1 | Accept every group destination |
| cfg_keep_short | input | 1 | Keep frames shorter than 64 bytes |
| cfg_drop_long | input | 1 | Drop frames longer than 1522 bytes |
| station_addr | input | 48 | Own address, byte 0 in bits 7:0 |
| group_table | input | 64 | Group-address hash table |
| rd_ptr | input | 14 | Host read pointer into the ring |
| stat_clr | input | 1 | Clear interrupt and status flags |
| in_valid | input | 1 | Frame byte valid |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Final byte of frame |
| in_ready | output | 1 | Byte accepted this cycle when valid |
| mem_we | output | 1 | Buffer byte write strobe |
| mem_addr | output | 14 | Buffer byte address |
| mem_wdata | output | 8 | Buffer byte data |
| wr_ptr | output | 14 | Committed receive write pointer |
| rx_irq | output | 1 | Frame-stored interrupt status |
| stat_group | output | 1 | Kept group-address frame seen |
| stat_short | output | 1 | Short frame rejected |

## Verification
The hardest case to reach is overflow inside a frame. The start-of-frame room check has already passed, but the frame is longer than the space left. This needs more than 1522 free bytes at the start, long frames allowed, and a frame that runs past the read pointer. The bench places `rd_ptr` 1600 bytes ahead of the write pointer, clears `cfg_drop_long`, and sends a 1700-byte frame. A write monitor then confirms that no byte offset reached 1600, and that the pointer and interrupt stayed put. The wrap across 16384 is reached by streaming back-to-back 1500-byte frames while the read pointer follows the write pointer.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    localparam int PTR_W = 14;
    localparam int LEN_W = 16;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DATA,
        S_DECIDE,
        S_PAD,
        S_HDR
    } rx_state_e;

    typedef struct packed {
        rx_state_e        st;
        logic [PTR_W-1:0] wp;
        logic [LEN_W-1:0] cnt;
        logic [LEN_W-1:0] room;
        logic             en;
        logic [1:0]       hsel;
        logic             irq;
        logic             s_grp;
        logic             s_short;
    } rx_regs_t;

    typedef struct packed {
        logic [31:0] crc;
        logic        hit;
        logic        grp;
    } flt_regs_t;
endpackage

// File: rtl/rxf_addr_filter.sv
module rxf_addr_filter
    import rxf_pkg::*;
#(
    parameter logic [31:0] POLY = 32'h04C11DB7
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        take_i,
    input  logic [2:0]  idx_i,
    input  logic [7:0]  data_i,
    input  logic [47:0] station_i,
    output logic        group_o,
    output logic        uni_hit_o,
    output logic [5:0]  hash_o
);
    flt_regs_t q, d;
    logic [7:0]  sta_byte;
    logic [31:0] crc_in;
    logic        hit_in;

    function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c;
        for (int k = 0; k < 8; k++) begin
            if (r[31] ^ b[k]) r = {r[30:0], 1'b0} ^ POLY;
            else              r = {r[30:0], 1'b0};
        end
        return r;
    endfunction

    always_comb begin
        d        = q;
        sta_byte = station_i[{idx_i, 3'b000} +: 8];
        crc_in   = (idx_i == 3'd0) ? 32'hFFFF_FFFF : q.crc;
        hit_in   = (idx_i == 3'd0) ? 1'b1 : q.hit;
        if (take_i) begin
            d.crc = crc_byte(crc_in, data_i);
            d.hit = hit_in && (data_i == sta_byte);
            if (idx_i == 3'd0) d.grp = data_i[0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.crc <= '1;
            q.hit <= 1'b0;
            q.grp <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign group_o   = q.grp;
    assign uni_hit_o = q.hit;
    assign hash_o    = q.crc[31:26];
endmodule

// File: rtl/rxf_ring_gap.sv
module rxf_ring_gap
    import rxf_pkg::*;
#(
    parameter int RING_BASE = 3072,
    parameter int RING_END  = 16384
) (
    input  logic [PTR_W-1:0] wp_i,
    input  logic [PTR_W-1:0] rd_i,
    output logic [LEN_W-1:0] gap_o
);
    localparam int RING = RING_END - RING_BASE;

    logic [PTR_W-1:0] fwd;
    logic [PTR_W-1:0] back;

    always_comb begin
        fwd  = rd_i - wp_i;
        back = wp_i - rd_i;
        if (rd_i > wp_i) gap_o = LEN_W'(fwd);
        else             gap_o = LEN_W'(RING) - LEN_W'(back);
    end
endmodule

// File: rtl/rxf_ring_add.sv
module rxf_ring_add
    import rxf_pkg::*;
#(
    parameter int RING_BASE = 3072,
    parameter int RING_END  = 16384
) (
    input  logic [PTR_W-1:0] base_i,
    input  logic [LEN_W:0]   off_i,
    output logic [PTR_W-1:0] addr_o
);
    localparam int RING = RING_END - RING_BASE;
    localparam int SW   = LEN_W + 2;

    logic [SW-1:0] sum;
    logic [SW-1:0] wrapped;

    always_comb begin
        sum = SW'(base_i) + SW'(off_i);
        if (sum >= SW'(RING_END)) wrapped = sum - SW'(RING);
        else                      wrapped = sum;
    end

    generate
        if (RING_END == (1 << PTR_W)) begin : g_pow2_end
            assign addr_o = wrapped[PTR_W-1:0];
        end else begin : g_gen_end
            assign addr_o = (wrapped >= SW'(RING_END)) ? PTR_W'(RING_BASE) : wrapped[PTR_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/rxf_ring_writer.sv
module rxf_ring_writer
    import rxf_pkg::*;
#(
    parameter int RING_BASE = 3072,
    parameter int RING_END  = 16384,
    parameter int MIN_LEN   = 64,
    parameter int MAX_LEN   = 1522,
    parameter int ROOM      = 1522
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_enable,
    input  logic             cfg_promisc,
    input  logic             cfg_all_group,
    input  logic             cfg_keep_short,
    input  logic             cfg_drop_long,
    input  logic [47:0]      station_addr,
    input  logic [63:0]      group_table,
    input  logic [PTR_W-1:0] rd_ptr,
    input  logic             stat_clr,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_last,
    output logic             in_ready,
    output logic             mem_we,
    output logic [PTR_W-1:0] mem_addr,
    output logic [7:0]       mem_wdata,
    output logic [PTR_W-1:0] wr_ptr,
    output logic             rx_irq,
    output logic             stat_group,
    output logic             stat_short
);
    localparam int         HDR_LEN  = 4;
    localparam int         ADDR_LEN = 6;
    localparam logic [LEN_W:0] HDR_OFF = (LEN_W+1)'(HDR_LEN);

    rx_regs_t q, d;

    logic [LEN_W-1:0] gap;
    logic [LEN_W-1:0] stored;
    logic [LEN_W:0]   foot;
    logic [LEN_W:0]   byte_off;
    logic [LEN_W:0]   off_c;
    logic [PTR_W-1:0] next_wp;
    logic             take;
    logic [2:0]       tidx;
    logic             f_group, f_hit;
    logic [5:0]       f_hash;
    logic             addr_ok, short_ok, long_ok, size_ok, fits, keep, short_flag;
    logic             ready_c, we_c;
    logic [7:0]       wd_c;
    logic             idle_w;

    rxf_addr_filter u_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .take_i    (take),
        .idx_i     (tidx),
        .data_i    (in_data),
        .station_i (station_addr),
        .group_o   (f_group),
        .uni_hit_o (f_hit),
        .hash_o    (f_hash)
    );

    rxf_ring_gap #(.RING_BASE(RING_BASE), .RING_END(RING_END)) u_gap (
        .wp_i  (q.wp),
        .rd_i  (rd_ptr),
        .gap_o (gap)
    );

    rxf_ring_add #(.RING_BASE(RING_BASE), .RING_END(RING_END)) u_wr_addr (
        .base_i (q.wp),
        .off_i  (off_c),
        .addr_o (mem_addr)
    );

    rxf_ring_add #(.RING_BASE(RING_BASE), .RING_END(RING_END)) u_commit (
        .base_i (q.wp),
        .off_i  (foot),
        .addr_o (next_wp)
    );

    // Decision terms, all taken from registered state after the last byte
    always_comb begin
        stored     = (q.cnt < LEN_W'(MIN_LEN)) ? LEN_W'(MIN_LEN) : q.cnt;
        foot       = HDR_OFF + (LEN_W+1)'(stored) + (LEN_W+1)'(stored[0]);
        byte_off   = HDR_OFF + (LEN_W+1)'(q.cnt);
        addr_ok    = cfg_promisc ||
                     (f_group ? (cfg_all_group || group_table[f_hash]) : f_hit);
        size_ok    = q.cnt >= LEN_W'(ADDR_LEN);
        short_ok   = (q.cnt >= LEN_W'(MIN_LEN)) || cfg_keep_short;
        long_ok    = !(cfg_drop_long && (q.cnt > LEN_W'(MAX_LEN)));
        fits       = foot < {1'b0, q.room};
        keep       = q.en && size_ok && addr_ok && short_ok && long_ok && fits;
        short_flag = q.en && size_ok && addr_ok && !short_ok;
    end

    always_comb begin
        d       = q;
        ready_c = 1'b0;
        we_c    = 1'b0;
        off_c   = '0;
        wd_c    = 8'h00;
        take    = 1'b0;
        tidx    = 3'd0;

        if (stat_clr) begin
            d.irq     = 1'b0;
            d.s_grp   = 1'b0;
            d.s_short = 1'b0;
        end

        case (q.st)
            S_IDLE: begin
                ready_c = !cfg_enable || (gap > LEN_W'(ROOM));
                off_c   = HDR_OFF;
                wd_c    = in_data;
                if (in_valid && ready_c) begin
                    d.en   = cfg_enable;
                    d.room = gap;
                    d.cnt  = LEN_W'(1);
                    take   = 1'b1;
                    we_c   = cfg_enable && (HDR_OFF < {1'b0, gap});
                    d.st   = in_last ? S_DECIDE : S_DATA;
                end
            end
            S_DATA: begin
                ready_c = 1'b1;
                off_c   = byte_off;
                wd_c    = in_data;
                if (in_valid) begin
                    we_c = q.en && (byte_off < {1'b0, q.room});
                    take = q.cnt < LEN_W'(ADDR_LEN);
                    tidx = q.cnt[2:0];
                    if (q.cnt != '1) d.cnt = q.cnt + LEN_W'(1);
                    if (in_last) d.st = S_DECIDE;
                end
            end
            S_DECIDE: begin
                if (short_flag) d.s_short = 1'b1;
                d.hsel = 2'd0;
                if (!keep)                          d.st = S_IDLE;
                else if (q.cnt < LEN_W'(MIN_LEN))   d.st = S_PAD;
                else                                d.st = S_HDR;
            end
            S_PAD: begin
                off_c = byte_off;
                wd_c  = 8'h00;
                we_c  = 1'b1;
                d.cnt = q.cnt + LEN_W'(1);
                if (q.cnt == LEN_W'(MIN_LEN - 1)) d.st = S_HDR;
            end
            S_HDR: begin
                off_c = (LEN_W+1)'(q.hsel);
                we_c  = 1'b1;
                case (q.hsel)
                    2'd0:    wd_c = 8'h01;
                    2'd1:    wd_c = 8'h00;
                    2'd2:    wd_c = stored[7:0];
                    default: wd_c = stored[15:8];
                endcase
                d.hsel = q.hsel + 2'd1;
                if (q.hsel == 2'd3) begin
                    d.wp  = next_wp;
                    d.irq = 1'b1;
                    if (f_group && !cfg_promisc) d.s_grp = 1'b1;
                    d.st  = S_IDLE;
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st      <= S_IDLE;
            q.wp      <= PTR_W'(RING_BASE);
            q.cnt     <= '0;
            q.room    <= '0;
            q.en      <= 1'b0;
            q.hsel    <= 2'd0;
            q.irq     <= 1'b0;
            q.s_grp   <= 1'b0;
            q.s_short <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign idle_w     = (q.st == S_IDLE);
    assign in_ready   = ready_c;
    assign mem_we     = we_c;
    assign mem_wdata  = wd_c;
    assign wr_ptr     = q.wp;
    assign rx_irq     = q.irq;
    assign stat_group = q.s_grp;
    assign stat_short = q.s_short;
endmodule

// File: rtl/rxf_ring_writer_chk.sv
module rxf_ring_writer_chk
    import rxf_pkg::*;
#(
    parameter int RING_BASE = 3072,
    parameter int RING_END  = 16384,
    parameter int ROOM      = 1522
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_enable,
    input logic [PTR_W-1:0] rd_ptr,
    input logic             in_ready,
    input logic             mem_we,
    input logic [PTR_W-1:0] mem_addr,
    input logic [PTR_W-1:0] wr_ptr,
    input logic             rx_irq,
    input logic             idle_w
);
    localparam int RING = RING_END - RING_BASE;

    int free_c;
    int off_c;

    always_comb begin
        if (int'(rd_ptr) > int'(wr_ptr)) free_c = int'(rd_ptr) - int'(wr_ptr);
        else                             free_c = RING - (int'(wr_ptr) - int'(rd_ptr));
        if (int'(mem_addr) >= int'(wr_ptr)) off_c = int'(mem_addr) - int'(wr_ptr);
        else                                off_c = int'(mem_addr) + RING - int'(wr_ptr);
    end

    p_wp_even_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ptr[0] == 1'b0) && (int'(wr_ptr) >= RING_BASE) && (int'(wr_ptr) < RING_END));

    p_wp_moves_with_irq_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wr_ptr) |-> rx_irq);

    p_no_overrun_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (off_c < free_c));

    p_addr_in_ring_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ((int'(mem_addr) >= RING_BASE) && (int'(mem_addr) < RING_END)));

    p_ready_room_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_w && cfg_enable && in_ready) |-> (free_c > ROOM));

    p_irq_after_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_irq) |-> $past(mem_we));
endmodule

bind rxf_ring_writer rxf_ring_writer_chk #(
    .RING_BASE (RING_BASE),
    .RING_END  (RING_END),
    .ROOM      (ROOM)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_enable (cfg_enable),
    .rd_ptr     (rd_ptr),
    .in_ready   (in_ready),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .wr_ptr     (wr_ptr),
    .rx_irq     (rx_irq),
    .idle_w     (idle_w)
);

// File: tb/rxf_ring_writer_test.sv
`timescale 1ns/1ps
module rxf_ring_writer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_enable = 1'b1, cfg_promisc = 1'b0, cfg_all_group = 1'b0;
    logic        cfg_keep_short = 1'b0, cfg_drop_long = 1'b1;
    logic [47:0] station_addr = {8'h55, 8'h44, 8'h33, 8'h22, 8'h11, 8'h02};
    logic [63:0] group_table = '0;
    logic [13:0] rd_ptr = 14'd3072;
    logic        stat_clr = 1'b0;
    logic        in_valid = 1'b0, in_last = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_ready, mem_we, rx_irq, stat_group, stat_short;
    logic [13:0] mem_addr, wr_ptr;
    logic [7:0]  mem_wdata;

    int tests = 0, fails = 0;
    int exp_wp = 3072;
    int nwrites = 0;
    int watch_on = 0, watch_base = 0, watch_lim = 0, bad_writes = 0;
    logic [7:0] mem [int];
    logic [7:0] dst [6];

    always #2.5 clk = ~clk;

    rxf_ring_writer uut (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_promisc(cfg_promisc),
        .cfg_all_group(cfg_all_group), .cfg_keep_short(cfg_keep_short),
        .cfg_drop_long(cfg_drop_long), .station_addr(station_addr),
        .group_table(group_table), .rd_ptr(rd_ptr), .stat_clr(stat_clr),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .wr_ptr(wr_ptr),
        .rx_irq(rx_irq), .stat_group(stat_group), .stat_short(stat_short)
    );

    // Buffer model, sampled between edges
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            mem[int'(mem_addr)] = mem_wdata;
            nwrites++;
            if (watch_on != 0) begin
                int off;
                off = int'(mem_addr) - watch_base;
                if (off < 0) off += 13312;
                if (off >= watch_lim) bad_writes++;
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish (actual timeout, expected completion)");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int wrapa(input int a);
        return (a >= 16384) ? a - 13312 : a;
    endfunction

    function automatic int getm(input int a);
        return mem.exists(a) ? int'(mem[a]) : -1;
    endfunction

    function automatic int fbyte(input int i, input int seed);
        return (i < 6) ? int'(dst[i]) : ((i * 3 + seed) & 255);
    endfunction

    function automatic int hash_of();
        logic [31:0] c;
        c = 32'hFFFF_FFFF;
        for (int b = 0; b < 6; b++)
            for (int k = 0; k < 8; k++)
                if (c[31] ^ dst[b][k]) c = {c[30:0], 1'b0} ^ 32'h04C11DB7;
                else                   c = {c[30:0], 1'b0};
        return int'(c[31:26]);
    endfunction

    function automatic int advance(input int wp, input int len);
        int s;
        s = (len < 64) ? 64 : len;
        return wrapa(wp + 4 + s + (s % 2));
    endfunction

    task automatic set_dst(input logic [47:0] a);
        for (int i = 0; i < 6; i++) dst[i] = a[8*i +: 8];
    endtask

    task automatic send(input int len, input int seed);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = 8'(fbyte(i, seed));
            in_last  = (i == len - 1);
            while (!in_ready) @(negedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        repeat (80) @(negedge clk);
    endtask

    task automatic clear_stat();
        @(negedge clk); stat_clr = 1'b1;
        @(negedge clk); stat_clr = 1'b0;
    endtask

    task automatic expect_kept(input int len, input int seed, input string req);
        int s, w;
        w = exp_wp;
        s = (len < 64) ? 64 : len;
        chk(rx_irq == 1'b1, {req, " irq"}, int'(rx_irq), 1);
        chk(getm(w) == 1 && getm(wrapa(w + 1)) == 0, {req, " hdr status"}, getm(w), 1);
        chk(getm(wrapa(w + 2)) == (s & 255) && getm(wrapa(w + 3)) == (s >> 8),
            {req, " hdr length"}, getm(wrapa(w + 2)) + 256 * getm(wrapa(w + 3)), s);
        chk(getm(wrapa(w + 4)) == fbyte(0, seed), {req, " first byte"}, getm(wrapa(w + 4)), fbyte(0, seed));
        chk(getm(wrapa(w + 3 + len)) == fbyte(len - 1, seed), {req, " last byte"},
            getm(wrapa(w + 3 + len)), fbyte(len - 1, seed));
        if (len < 64)
            chk(getm(wrapa(w + 4 + len)) == 0 && getm(wrapa(w + 67)) == 0, {req, " padding"},
                getm(wrapa(w + 67)), 0);
        exp_wp = advance(w, len);
        chk(int'(wr_ptr) == exp_wp, {req, " wr_ptr"}, int'(wr_ptr), exp_wp);
        clear_stat();
        rd_ptr = 14'(exp_wp);
    endtask

    task automatic expect_dropped(input string req);
        chk(int'(wr_ptr) == exp_wp, {req, " wr_ptr kept"}, int'(wr_ptr), exp_wp);
        chk(rx_irq == 1'b0, {req, " no irq"}, int'(rx_irq), 0);
    endtask

    task automatic t_reset();
        chk(int'(wr_ptr) == 3072, "R9 reset wr_ptr", int'(wr_ptr), 3072);
        chk(rx_irq == 0 && stat_group == 0 && stat_short == 0, "R11 reset flags", int'(rx_irq), 0);
        chk(in_ready == 1'b1, "R2 ready on empty ring", int'(in_ready), 1);
    endtask

    task automatic t_unicast();
        set_dst(station_addr);
        send(100, 1);
        expect_kept(100, 1, "R3 unicast match");
        set_dst(48'h55_44_33_22_11_04);
        send(100, 2);
        expect_dropped("R3 unicast mismatch");
        expect_dropped("R12 dropped unicast");
    endtask

    task automatic t_promisc();
        cfg_promisc = 1'b1;
        set_dst(48'h99_88_77_66_55_44);
        send(80, 3);
        expect_kept(80, 3, "R5 promiscuous");
        cfg_promisc = 1'b0;
    endtask

    task automatic t_group();
        int h;
        set_dst(48'hFB_00_00_5E_00_01);
        cfg_all_group = 1'b1;
        send(70, 4);
        chk(stat_group == 1'b1, "R4 group status all", int'(stat_group), 1);
        expect_kept(70, 4, "R4 all-group");
        cfg_all_group = 1'b0;
        h = hash_of();
        group_table = 64'd1 << h;
        send(70, 5);
        chk(stat_group == 1'b1, "R4 group status hash", int'(stat_group), 1);
        expect_kept(70, 5, "R4 hash hit");
        group_table = ~(64'd1 << h);
        send(70, 6);
        expect_dropped("R4 hash miss");
        chk(stat_group == 1'b0, "R4 no status on miss", int'(stat_group), 0);
        group_table = '0;
    endtask

    task automatic t_short();
        set_dst(station_addr);
        send(40, 7);
        expect_dropped("R6 short dropped");
        chk(stat_short == 1'b1, "R6 short status", int'(stat_short), 1);
        clear_stat();
        chk(stat_short == 1'b0, "R11 stat_clr", int'(stat_short), 0);
        cfg_keep_short = 1'b1;
        send(40, 8);
        expect_kept(40, 8, "R6 R8 short kept padded");
        send(5, 9);
        expect_dropped("R6 under six bytes");
        cfg_keep_short = 1'b0;
    endtask

    task automatic t_odd();
        set_dst(station_addr);
        send(101, 10);
        expect_kept(101, 10, "R9 odd length");
    endtask

    task automatic t_long();
        set_dst(station_addr);
        send(1530, 11);
        expect_dropped("R7 long dropped");
        cfg_drop_long = 1'b0;
        send(1530, 12);
        expect_kept(1530, 12, "R7 long kept");
        cfg_drop_long = 1'b1;
    endtask

    task automatic t_disable();
        int n0;
        cfg_enable = 1'b0;
        set_dst(station_addr);
        n0 = nwrites;
        send(100, 13);
        chk(nwrites == n0, "R1 no writes when disabled", nwrites - n0, 0);
        expect_dropped("R1 disabled");
        cfg_enable = 1'b1;
    endtask

    task automatic t_room();
        @(negedge clk);
        rd_ptr = 14'(wrapa(exp_wp + 1522));
        #1;
        chk(in_ready == 1'b0, "R2 room 1522 stalls", int'(in_ready), 0);
        @(negedge clk);
        rd_ptr = 14'(wrapa(exp_wp + 1524));
        #1;
        chk(in_ready == 1'b1, "R2 room 1524 accepts", int'(in_ready), 1);
        rd_ptr = 14'(exp_wp);
    endtask

    task automatic t_overflow();
        @(negedge clk);
        rd_ptr = 14'(wrapa(exp_wp + 1600));
        cfg_drop_long = 1'b0;
        watch_base = exp_wp; watch_lim = 1600; bad_writes = 0; watch_on = 1;
        set_dst(station_addr);
        send(1700, 14);
        watch_on = 0;
        chk(bad_writes == 0, "R10 no write past read pointer", bad_writes, 0);
        expect_dropped("R10 overflow");
        cfg_drop_long = 1'b1;
        rd_ptr = 14'(exp_wp);
    endtask

    task automatic t_wrap();
        int crossed, old;
        crossed = 0;
        set_dst(station_addr);
        for (int f = 0; f < 12 && crossed == 0; f++) begin
            old = exp_wp;
            send(1500, 20 + f);
            expect_kept(1500, 20 + f, "R8 R9 ring march");
            if (exp_wp < old) crossed = 1;
        end
        chk(crossed == 1, "R9 wrap to ring base", crossed, 1);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unicast();
        t_promisc();
        t_group();
        t_short();
        t_odd();
        t_long();
        t_disable();
        t_room();
        t_overflow();
        t_wrap();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule